// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block carries a processor core through entry into an external interrupt. When a request arrives with a vector number, the block captures the core's status word, its user-mode flag, the program counter, the stack pointer, the saved kernel stack pointer and the vector table base. If interrupts are disabled in the status word, the request is dropped and the block reports that it was not taken. Otherwise the block steps through a fixed order of register updates, presented as write strobes with data. First it leaves user mode. Then it writes the shifted status word, swaps stacks if the core was in user mode, stores the return address and records the exception cause.

Next it issues one word read to the vector table and holds the request until the memory grants it. It accepts the response. It then either loads the program counter with the handler address or, if the response is an error, flags the failing address and leaves the program counter alone. A one-cycle completion pulse ends every request, and a flag with it says whether the interrupt was taken. The reset input is asserted asynchronously and its release is resynchronised inside the block.

Top module: `irq_entry_seq`

## Requirements
- R1: For at least two cycles after reset release, and until a request is accepted, every write strobe, `mem_req`, `err_valid` and `done` stay low.
- R2: A request sampled while status bit IE_BIT (default 8) is 0 writes no register and issues no read. The cycle after acceptance it gives `done`=1 with `taken`=0.
- R3: With IE_BIT set, the cycle after acceptance raises `user_clr` alone. No other write strobe or read request is high in that cycle.
- R4: In the cycle after `user_clr`, `ccs_we` is high with `ccs_wdata` = ((old << 10) AND 0x3FFF_FFFF) OR (old AND 0x8000_0000).
- R5: In that same cycle, if the captured user flag was 1, `usp_we` writes the old stack pointer and `sp_we` writes the kernel stack pointer. If it was 0, neither strobe rises.
- R6: In that same cycle, `erp_we` writes the captured PC, `exs_we` writes vector×256 and `eda_clr` is high.
- R7: The cycle after the register updates, `mem_req` rises with `mem_addr` = base + vector×4. It stays high with a stable address until a cycle with `mem_gnt` high, and falls the cycle after that cycle. Only one read is issued per request.
- R8: Response byte lane k (`rsp_data` bits 8k+7:8k) holds the byte at `mem_addr`+k. The handler address is these bytes in little-endian order. In the cycle `rsp_valid` is high with `rsp_err`=0, `pc_we` is high with that address.
- R9: A response with `rsp_err`=1 gives `err_valid`=1 with `err_addr` equal to the read address in that cycle. `pc_we` stays low, and the next cycle gives `done`=1 with `taken`=0.
- R10: The cycle after a good response gives `done`=1 with `taken`=1. `done` lasts exactly one cycle, and a new request is accepted in the cycle after it.
- R11: All request inputs are captured in the accepting cycle. Later changes on them do not alter any written value or the read address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_valid | input | 1 | Interrupt request, sampled when idle |
| irq_vec | input | VEC_W | Vector number |
| ccs_in | input | XLEN | Current status word |
| user_in | input | 1 | Core is in user mode |
| pc_in | input | XLEN | Current program counter |
| sp_in | input | XLEN | Current stack pointer |
| ksp_in | input | XLEN | Saved kernel stack pointer |
| ebp_in | input | XLEN | Vector table base |
| user_clr | output | 1 | Force user mode off |
| ccs_we | output | 1 | Status word write |
| ccs_wdata | output | XLEN | New status word |
| usp_we | output | 1 | User stack pointer save |
| usp_wdata | output | XLEN | Saved user stack pointer |
| sp_we | output | 1 | Stack pointer write |
| sp_wdata | output | XLEN | Kernel stack pointer value |
| erp_we | output | 1 | Return address write |
| erp_wdata | output | XLEN | Return address |
| exs_we | output | 1 | Exception cause write |
| exs_wdata | output | XLEN | Vector × 256 |
| eda_clr | output | 1 | Clear exception data address |
| mem_req | output | 1 | Vector read request |
| mem_addr | output | XLEN | Vector read address |
| mem_gnt | input | 1 | Request accepted by memory |
| rsp_valid | input | 1 | Read response present |
| rsp_err | input | 1 | Response is an error (unmapped) |
| rsp_data | input | XLEN | Response byte lanes |
| pc_we | output | 1 | Program counter write |
| pc_wdata | output | XLEN | Handler address |
| err_valid | output | 1 | Vector read failed |
| err_addr | output | XLEN | Failing address |
| done | output | 1 | Completion pulse |
| taken | output | 1 | Interrupt was taken, valid with done |

## Verification
The assertions watch the ordering on every cycle. A status write must follow the leave-user-mode strobe. The stack swap must coincide with the status write. A pending read must hold its address until granted and must drop after the grant. A program counter load must be followed by a taken completion, an error by a not-taken one, and completion must last a single cycle. The written values are shown only by the bench's scenarios. These values are the shifted status word, the vector-scaled cause and address, the byte-lane assembly of the handler, and the values captured at acceptance. The bench also alone shows that a disabled request touches nothing.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_KERNEL  = 3'd1,
    ST_UPDATE  = 3'd2,
    ST_RD_REQ  = 3'd3,
    ST_RD_WAIT = 3'd4,
    ST_DONE    = 3'd5
  } entry_state_e;
endpackage

// File: rtl/irq_entry_rstsync.sv
module irq_entry_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_sync_n <= stage_q;
    end
  end
endmodule

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl
  import irq_entry_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic irq_valid,
  input  logic irq_en,
  input  logic mem_gnt,
  input  logic rsp_valid,
  input  logic rsp_err,
  output logic cap_en,
  output logic user_clr,
  output logic upd_en,
  output logic mem_req,
  output logic fetch_end,
  output logic done,
  output logic taken
);
  entry_state_e state_q, state_d;
  logic taken_q, taken_d, taken_en;

  // next-state logic
  always_comb begin
    state_d  = state_q;
    taken_d  = taken_q;
    taken_en = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (irq_valid) begin
          state_d  = irq_en ? ST_KERNEL : ST_DONE;
          taken_d  = 1'b0;
          taken_en = 1'b1;
        end
      end
      ST_KERNEL:  state_d = ST_UPDATE;
      ST_UPDATE:  state_d = ST_RD_REQ;
      ST_RD_REQ:  if (mem_gnt) state_d = ST_RD_WAIT;
      ST_RD_WAIT: begin
        if (rsp_valid) begin
          state_d  = ST_DONE;
          taken_d  = ~rsp_err;
          taken_en = 1'b1;
        end
      end
      ST_DONE:    state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  // state register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        taken_q <= 1'b0;
    else if (taken_en) taken_q <= taken_d;
  end

  always_comb begin
    cap_en    = (state_q == ST_IDLE) && irq_valid;
    user_clr  = (state_q == ST_KERNEL);
    upd_en    = (state_q == ST_UPDATE);
    mem_req   = (state_q == ST_RD_REQ);
    fetch_end = (state_q == ST_RD_WAIT) && rsp_valid;
    done      = (state_q == ST_DONE);
    taken     = taken_q;
  end
endmodule

// File: rtl/irq_entry_calc.sv
module irq_entry_calc #(
  parameter int XLEN        = 32,
  parameter int VEC_W       = 8,
  parameter int SR_SHIFT    = 10,
  parameter int SR_WIN      = 30,
  parameter int CAUSE_SHIFT = 8,
  parameter int ENTRY_BYTES = 4
) (
  input  logic [XLEN-1:0]  ccs,
  input  logic [VEC_W-1:0] vec,
  input  logic [XLEN-1:0]  base,
  output logic [XLEN-1:0]  ccs_new,
  output logic [XLEN-1:0]  cause,
  output logic [XLEN-1:0]  vaddr
);
  localparam int ENTRY_SHIFT = $clog2(ENTRY_BYTES);
  localparam logic [XLEN-1:0] WIN_MASK = {XLEN{1'b1}} >> (XLEN - SR_WIN);
  localparam logic [XLEN-1:0] TOP_MASK = {1'b1, {(XLEN-1){1'b0}}};

  logic [XLEN-1:0] vec_ext;

  always_comb begin
    vec_ext = XLEN'(vec);
    ccs_new = ((ccs << SR_SHIFT) & WIN_MASK) | (ccs & TOP_MASK);
    cause   = vec_ext << CAUSE_SHIFT;
    vaddr   = base + (vec_ext << ENTRY_SHIFT);
  end
endmodule

// File: rtl/irq_entry_lanes.sv
module irq_entry_lanes #(
  parameter int XLEN   = 32,
  parameter bit LITTLE = 1'b1
) (
  input  logic [XLEN-1:0] lanes,
  output logic [XLEN-1:0] word
);
  localparam int NLANES = XLEN / 8;

  for (genvar k = 0; k < NLANES; k++) begin : g_lane
    if (LITTLE) begin : g_le
      assign word[8*k +: 8] = lanes[8*k +: 8];
    end else begin : g_be
      assign word[8*k +: 8] = lanes[8*(NLANES-1-k) +: 8];
    end
  end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq #(
  parameter int XLEN        = 32,
  parameter int VEC_W       = 8,
  parameter int IE_BIT      = 8,
  parameter int SR_SHIFT    = 10,
  parameter int SR_WIN      = 30,
  parameter int CAUSE_SHIFT = 8,
  parameter int ENTRY_BYTES = 4,
  parameter bit LITTLE      = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             irq_valid,
  input  logic [VEC_W-1:0] irq_vec,
  input  logic [XLEN-1:0]  ccs_in,
  input  logic             user_in,
  input  logic [XLEN-1:0]  pc_in,
  input  logic [XLEN-1:0]  sp_in,
  input  logic [XLEN-1:0]  ksp_in,
  input  logic [XLEN-1:0]  ebp_in,
  output logic             user_clr,
  output logic             ccs_we,
  output logic [XLEN-1:0]  ccs_wdata,
  output logic             usp_we,
  output logic [XLEN-1:0]  usp_wdata,
  output logic             sp_we,
  output logic [XLEN-1:0]  sp_wdata,
  output logic             erp_we,
  output logic [XLEN-1:0]  erp_wdata,
  output logic             exs_we,
  output logic [XLEN-1:0]  exs_wdata,
  output logic             eda_clr,
  output logic             mem_req,
  output logic [XLEN-1:0]  mem_addr,
  input  logic             mem_gnt,
  input  logic             rsp_valid,
  input  logic             rsp_err,
  input  logic [XLEN-1:0]  rsp_data,
  output logic             pc_we,
  output logic [XLEN-1:0]  pc_wdata,
  output logic             err_valid,
  output logic [XLEN-1:0]  err_addr,
  output logic             done,
  output logic             taken
);
  logic rst_sync_n;
  logic cap_en, upd_en, fetch_end;

  logic [XLEN-1:0]  cap_ccs, cap_pc, cap_sp, cap_ksp, cap_ebp;
  logic [VEC_W-1:0] cap_vec;
  logic             cap_user;
  logic [XLEN-1:0]  vaddr, handler;

  irq_entry_rstsync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  irq_entry_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .irq_valid (irq_valid),
    .irq_en    (ccs_in[IE_BIT]),
    .mem_gnt   (mem_gnt),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err),
    .cap_en    (cap_en),
    .user_clr  (user_clr),
    .upd_en    (upd_en),
    .mem_req   (mem_req),
    .fetch_end (fetch_end),
    .done      (done),
    .taken     (taken)
  );

  // capture of the request context, enabled in the accepting cycle
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      cap_ccs  <= '0;
      cap_pc   <= '0;
      cap_sp   <= '0;
      cap_ksp  <= '0;
      cap_ebp  <= '0;
      cap_vec  <= '0;
      cap_user <= 1'b0;
    end else if (cap_en) begin
      cap_ccs  <= ccs_in;
      cap_pc   <= pc_in;
      cap_sp   <= sp_in;
      cap_ksp  <= ksp_in;
      cap_ebp  <= ebp_in;
      cap_vec  <= irq_vec;
      cap_user <= user_in;
    end
  end

  irq_entry_calc #(
    .XLEN        (XLEN),
    .VEC_W       (VEC_W),
    .SR_SHIFT    (SR_SHIFT),
    .SR_WIN      (SR_WIN),
    .CAUSE_SHIFT (CAUSE_SHIFT),
    .ENTRY_BYTES (ENTRY_BYTES)
  ) u_calc (
    .ccs     (cap_ccs),
    .vec     (cap_vec),
    .base    (cap_ebp),
    .ccs_new (ccs_wdata),
    .cause   (exs_wdata),
    .vaddr   (vaddr)
  );

  irq_entry_lanes #(
    .XLEN   (XLEN),
    .LITTLE (LITTLE)
  ) u_lanes (
    .lanes (rsp_data),
    .word  (handler)
  );

  always_comb begin
    ccs_we    = upd_en;
    usp_we    = upd_en & cap_user;
    usp_wdata = cap_sp;
    sp_we     = upd_en & cap_user;
    sp_wdata  = cap_ksp;
    erp_we    = upd_en;
    erp_wdata = cap_pc;
    exs_we    = upd_en;
    eda_clr   = upd_en;
    mem_addr  = vaddr;
    pc_we     = fetch_end & ~rsp_err;
    pc_wdata  = handler;
    err_valid = fetch_end & rsp_err;
    err_addr  = vaddr;
  end
endmodule

// File: rtl/irq_entry_chk.sv
module irq_entry_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            user_clr,
  input logic            ccs_we,
  input logic            usp_we,
  input logic            sp_we,
  input logic            mem_req,
  input logic            mem_gnt,
  input logic [XLEN-1:0] mem_addr,
  input logic            pc_we,
  input logic            err_valid,
  input logic            done,
  input logic            taken
);
  // R3: the status write always follows the leave-user-mode cycle
  a_r3_kernel_first: assert property (@(posedge clk) disable iff (!rst_n)
    ccs_we |-> $past(user_clr));

  // R3: leaving user mode happens alone
  a_r3_alone: assert property (@(posedge clk) disable iff (!rst_n)
    user_clr |-> !ccs_we && !mem_req && !pc_we);

  // R5: stack swap happens together with the status write
  a_r5_swap_pair: assert property (@(posedge clk) disable iff (!rst_n)
    usp_we |-> sp_we && ccs_we);

  // R7: pending request holds with a stable address
  a_r7_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_addr));

  // R7: a granted request is not repeated
  a_r7_single: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_gnt |=> !mem_req);

  // R8: a handler load ends in a taken completion
  a_r8_load_taken: assert property (@(posedge clk) disable iff (!rst_n)
    pc_we |=> done && taken);

  // R9: an error ends in a not-taken completion
  a_r9_err_not_taken: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |=> done && !taken);

  // R10: completion lasts one cycle
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind irq_entry_seq irq_entry_chk #(.XLEN(XLEN)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .user_clr  (user_clr),
  .ccs_we    (ccs_we),
  .usp_we    (usp_we),
  .sp_we     (sp_we),
  .mem_req   (mem_req),
  .mem_gnt   (mem_gnt),
  .mem_addr  (mem_addr),
  .pc_we     (pc_we),
  .err_valid (err_valid),
  .done      (done),
  .taken     (taken)
);

// File: tb/sim_irq_entry_seq.sv
module sim_irq_entry_seq;
  localparam int CLK_PERIOD = 10;
  localparam int XLEN  = 32;
  localparam int VEC_W = 8;
  localparam int IEB   = 8;
  localparam int WATCHDOG = 100000;

  logic clk = 1'b0;
  logic rst_n;
  logic irq_valid;
  logic [VEC_W-1:0] irq_vec;
  logic [XLEN-1:0] ccs_in, pc_in, sp_in, ksp_in, ebp_in;
  logic user_in;
  logic user_clr, ccs_we, usp_we, sp_we, erp_we, exs_we, eda_clr;
  logic [XLEN-1:0] ccs_wdata, usp_wdata, sp_wdata, erp_wdata, exs_wdata;
  logic mem_req, mem_gnt, rsp_valid, rsp_err;
  logic [XLEN-1:0] mem_addr, rsp_data, pc_wdata, err_addr;
  logic pc_we, err_valid, done, taken;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_entry_seq #(.XLEN(XLEN), .VEC_W(VEC_W), .IE_BIT(IEB)) u0 (
    .clk(clk), .rst_n(rst_n), .irq_valid(irq_valid), .irq_vec(irq_vec),
    .ccs_in(ccs_in), .user_in(user_in), .pc_in(pc_in), .sp_in(sp_in),
    .ksp_in(ksp_in), .ebp_in(ebp_in), .user_clr(user_clr),
    .ccs_we(ccs_we), .ccs_wdata(ccs_wdata), .usp_we(usp_we),
    .usp_wdata(usp_wdata), .sp_we(sp_we), .sp_wdata(sp_wdata),
    .erp_we(erp_we), .erp_wdata(erp_wdata), .exs_we(exs_we),
    .exs_wdata(exs_wdata), .eda_clr(eda_clr), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_gnt(mem_gnt), .rsp_valid(rsp_valid),
    .rsp_err(rsp_err), .rsp_data(rsp_data), .pc_we(pc_we),
    .pc_wdata(pc_wdata), .err_valid(err_valid), .err_addr(err_addr),
    .done(done), .taken(taken)
  );

  task automatic chk(input bit ok, input string tag, input logic [XLEN-1:0] act,
                     input logic [XLEN-1:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_eq(input string tag, input logic [XLEN-1:0] act,
                        input logic [XLEN-1:0] exp);
    chk(act === exp, tag, act, exp);
  endtask

  function automatic logic [XLEN-1:0] any_writes();
    return {25'd0, user_clr, ccs_we, usp_we, sp_we, erp_we, exs_we, mem_req | eda_clr};
  endfunction

  // caller is at a negedge with the block idle
  task automatic run_irq(input logic [VEC_W-1:0] v, input logic [XLEN-1:0] c,
                         input bit u, input logic [XLEN-1:0] pc,
                         input logic [XLEN-1:0] sp, input logic [XLEN-1:0] ksp,
                         input logic [XLEN-1:0] ebp, input int gd, input int rd,
                         input bit err, input logic [7:0] b0, input logic [7:0] b1,
                         input logic [7:0] b2, input logic [7:0] b3);
    logic [XLEN-1:0] e_ccs, e_addr, e_hdl;
    e_ccs  = ((c << 10) & 32'h3FFF_FFFF) | (c & 32'h8000_0000);
    e_addr = ebp + 32'(v) * 4;
    e_hdl  = 32'(b0) + (32'(b1) << 8) + (32'(b2) << 16) + (32'(b3) << 24);
    irq_valid = 1'b1; irq_vec = v; ccs_in = c; user_in = u;
    pc_in = pc; sp_in = sp; ksp_in = ksp; ebp_in = ebp;
    @(negedge clk);
    // R11: scramble inputs after acceptance
    irq_valid = 1'b0; irq_vec = ~v; ccs_in = ~c; user_in = ~u;
    pc_in = ~pc; sp_in = ~sp; ksp_in = ~ksp; ebp_in = ~ebp;
    if (!c[IEB]) begin
      chk_eq("R2 no writes when disabled", any_writes(), 32'd0);
      chk_eq("R2 done", 32'(done), 32'd1);
      chk_eq("R2 not taken", 32'(taken), 32'd0);
      @(negedge clk);
      chk_eq("R10 done pulse ends", 32'(done), 32'd0);
      chk_eq("R2 still no writes", any_writes(), 32'd0);
      return;
    end
    chk_eq("R3 user_clr alone", any_writes(), 32'h40);
    @(negedge clk);
    chk_eq("R3 user_clr dropped", 32'(user_clr), 32'd0);
    chk_eq("R4 ccs_we", 32'(ccs_we), 32'd1);
    chk_eq("R4 ccs value", ccs_wdata, e_ccs);
    chk_eq("R5 usp_we", 32'(usp_we), 32'(u));
    chk_eq("R5 sp_we", 32'(sp_we), 32'(u));
    if (u) begin
      chk_eq("R5 usp value R11", usp_wdata, sp);
      chk_eq("R5 sp value R11", sp_wdata, ksp);
    end
    chk_eq("R6 erp_we", 32'(erp_we), 32'd1);
    chk_eq("R6 erp value R11", erp_wdata, pc);
    chk_eq("R6 exs_we", 32'(exs_we), 32'd1);
    chk_eq("R6 exs value", exs_wdata, 32'(v) * 256);
    chk_eq("R6 eda_clr", 32'(eda_clr), 32'd1);
    chk_eq("R7 no early req", 32'(mem_req), 32'd0);
    @(negedge clk);
    for (int i = 0; i < gd; i++) begin
      chk_eq("R7 req held", 32'(mem_req), 32'd1);
      chk_eq("R7 addr R11", mem_addr, e_addr);
      @(negedge clk);
    end
    chk_eq("R7 req", 32'(mem_req), 32'd1);
    chk_eq("R7 addr", mem_addr, e_addr);
    mem_gnt = 1'b1;
    @(negedge clk);
    mem_gnt = 1'b0;
    for (int i = 0; i < rd; i++) begin
      chk_eq("R7 single request", 32'(mem_req), 32'd0);
      chk_eq("R8 no early pc_we", 32'(pc_we | err_valid), 32'd0);
      @(negedge clk);
    end
    chk_eq("R7 req dropped", 32'(mem_req), 32'd0);
    rsp_valid = 1'b1; rsp_err = err; rsp_data = {b3, b2, b1, b0};
    #1;
    if (err) begin
      chk_eq("R9 err_valid", 32'(err_valid), 32'd1);
      chk_eq("R9 err_addr", err_addr, e_addr);
      chk_eq("R9 no pc_we", 32'(pc_we), 32'd0);
    end else begin
      chk_eq("R8 pc_we", 32'(pc_we), 32'd1);
      chk_eq("R8 handler", pc_wdata, e_hdl);
      chk_eq("R8 no err", 32'(err_valid), 32'd0);
    end
    @(negedge clk);
    rsp_valid = 1'b0; rsp_err = 1'b0;
    chk_eq("R10 done", 32'(done), 32'd1);
    chk_eq("R10 R9 taken flag", 32'(taken), 32'(!err));
    @(negedge clk);
    chk_eq("R10 done pulse ends", 32'(done), 32'd0);
  endtask

  initial begin
    rst_n = 1'b0; irq_valid = 1'b0; irq_vec = '0; ccs_in = '0; user_in = 1'b0;
    pc_in = '0; sp_in = '0; ksp_in = '0; ebp_in = '0;
    mem_gnt = 1'b0; rsp_valid = 1'b0; rsp_err = 1'b0; rsp_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) begin
      chk_eq("R1 reset idle", any_writes(), 32'd0);
      chk_eq("R1 no done", 32'(done | err_valid | pc_we), 32'd0);
      @(negedge clk);
    end
    // disabled requests
    for (int v = 0; v < 4; v++) begin
      logic [XLEN-1:0] c;
      c = (32'hA5C3_0F17 ^ (32'(v) * 32'h0101_0101)) & ~(32'd1 << IEB);
      run_irq(8'(v * 37), c, v[0], 32'h100 + 32'(v), 32'h200, 32'h300, 32'h400,
              0, 0, 1'b0, 8'h11, 8'h22, 8'h33, 8'h44);
    end
    // sweep over vector, mode, error and handshake delays
    for (int vi = 0; vi < 8; vi++) begin
      for (int u = 0; u < 2; u++) begin
        for (int e = 0; e < 2; e++) begin
          for (int d = 0; d < 3; d++) begin
            logic [7:0] v;
            logic [XLEN-1:0] c;
            v = (vi == 7) ? 8'hFF : 8'(vi * 36 + d);
            c = ((32'h8765_4321 * 32'(vi + 1)) ^ (32'(u) << 31) ^ (32'(e) << 30))
                | (32'd1 << IEB);
            run_irq(v, c, u[0], 32'h4000_0000 + 32'(vi) * 2,
                    32'hC000_0000 + 32'(vi), 32'hD000_0000 - 32'(vi),
                    (vi == 6) ? 32'hFFFF_FF00 : 32'h0000_1000 * 32'(vi + 1),
                    d, 2 - d, e[0], 8'(vi + 1), 8'(u * 16 + 2), 8'(e * 64 + 3),
                    8'(d * 32 + 4));
          end
        end
      end
    end
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule